// File: doc/BRIEF.md
# Compare Flag Generation Unit

This block evaluates an 8-bit comparison by subtracting one operand from another, discarding the difference and producing the six status flags the result implies: zero, carry (borrow), negative, overflow, sign and half-carry. It has three modes. The register mode subtracts a second register operand. The immediate mode subtracts a constant field. The chained mode also subtracts the incoming carry, so that a compare of a wide value can be built one byte at a time, starting from the low byte.

The block registers its flags. A request presented with `cmp_go` high is evaluated, and its flags appear on the outputs after the next rising clock edge. While `cmp_go` is low the flags hold their value. The status register that supplies `c_in` and `z_in` lives outside the block, as do the register file and the decoder.

The block has no sequencer. Its only stored state is the flag register, and that register takes one of two transitions each cycle. UPDATE happens when `cmp_go` is high and loads new flags. HOLD happens when `cmp_go` is low and keeps the current flags. Reset puts the register into its CLEAR state, with all flags zero.

Top module: `cmpflag_unit`

## Requirements
- R1: While `rst_n` is low, all six flag outputs are 0.
- R2: `cmp_op` = 0 (register mode) computes `opd - opr`. The flags appear on the outputs one clock edge after the request with `cmp_go` = 1.
- R3: `cmp_op` = 1 (chained mode) computes `opd - opr - c_in`.
- R4: `cmp_op` = 2 (immediate mode) computes `opd - imm`. The value on `opr` has no effect in this mode.
- R5: `flag_c` is 1 exactly when the full 8-bit subtraction borrows out of bit 7, that is, when the unsigned minuend is smaller than the subtrahend plus any borrow-in.
- R6: `flag_h` is 1 exactly when the subtraction of the low nibbles, including any borrow-in, borrows out of bit 3.
- R7: `flag_n` equals bit 7 of the difference. `flag_v` is 1 when the signed difference falls outside -128..127. `flag_s` equals `flag_n` xor `flag_v`, which is the true sign of the signed difference.
- R8: In register mode and immediate mode, `flag_z` is 1 exactly when the difference is zero. In chained mode, a nonzero difference clears `flag_z`, and a zero difference makes `flag_z` equal to `z_in`.
- R9: While `cmp_go` is 0, all six flags keep their value, whatever the other inputs do.
- R10: `c_in` has no effect in register mode or in immediate mode.
- R11: `cmp_op` = 3 behaves exactly like register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_go | input | 1 | Evaluate a compare this cycle |
| cmp_op | input | 2 | Mode: 0 register, 1 chained, 2 immediate, 3 same as 0 |
| opd | input | 8 | Minuend operand |
| opr | input | 8 | Subtrahend operand in register and chained modes |
| imm | input | 8 | Subtrahend constant in immediate mode |
| c_in | input | 1 | Borrow-in for chained mode |
| z_in | input | 1 | Prior zero flag for chained mode |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry (borrow) flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Two's-complement overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_h | output | 1 | Half-carry (nibble borrow) flag |

## Verification
The bench targets four kinds of corner case.

The first is the chained zero rule: a zero difference with `z_in` low, a zero difference with `z_in` high, and a borrow-in that turns equal operands into 0xFF. A design that simply recomputed Z would report two-byte values as equal when their high bytes match and their low bytes differ.

The second is the overflow edges, 0x80 - 0x01 and 0x7F - 0xFF. There N and the true sign disagree, so a design that took S straight from bit 7 would fail.

The third is nibble-only borrows such as 0x10 - 0x01. These catch an H flag taken from the wrong bit.

The fourth covers the ignored inputs: `c_in` in the modes that do not chain, `opr` in immediate mode, and any input change while `cmp_go` is low. A design that leaked any of these would show altered flags.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
    typedef enum logic [1:0] {
        CMP_REG   = 2'd0,
        CMP_CHAIN = 2'd1,
        CMP_IMM   = 2'd2,
        CMP_ALT   = 2'd3
    } cmp_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
        logic s;
        logic h;
    } flags_t;
endpackage

// File: rtl/cmpflag_sub.sv
module cmpflag_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         bin,
    output logic [W-1:0] diff,
    output logic         bout,
    output logic         hbout
);
    localparam int HB = W / 2;

    logic [W:0] brw;

    assign brw[0] = bin;

    // Ripple borrow chain, one stage per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i]  = a[i] ^ b[i] ^ brw[i];
        assign brw[i+1] = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & brw[i]);
    end

    assign bout  = brw[W];
    assign hbout = brw[HB];
endmodule

// File: rtl/cmpflag_eval.sv
module cmpflag_eval
    import cmpflag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] diff,
    input  logic         bout,
    input  logic         hbout,
    input  logic         chain,
    input  logic         z_prev,
    output flags_t       flags
);
    localparam int MSB = W - 1;

    logic is_zero;
    logic ovf;

    assign is_zero = (diff == '0);
    // Overflow: the operand signs differ and the result sign differs from a.
    assign ovf = (a[MSB] ^ b[MSB]) & (a[MSB] ^ diff[MSB]);

    always_comb begin
        flags.c = bout;
        flags.h = hbout;
        flags.n = diff[MSB];
        flags.v = ovf;
        flags.s = diff[MSB] ^ ovf;
        flags.z = chain ? (is_zero & z_prev) : is_zero;
    end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_go,
    input  logic [1:0]   cmp_op,
    input  logic [W-1:0] opd,
    input  logic [W-1:0] opr,
    input  logic [W-1:0] imm,
    input  logic         c_in,
    input  logic         z_in,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_n,
    output logic         flag_v,
    output logic         flag_s,
    output logic         flag_h
);
    cmp_op_e     op;
    logic [W-1:0] subtr;
    logic         bin;
    logic         chain;
    logic [W-1:0] diff;
    logic         bout;
    logic         hbout;
    flags_t       flags_d;
    flags_t       flags_q;

    assign op = cmp_op_e'(cmp_op);

    // Operand and borrow-in selection per mode.
    always_comb begin
        unique case (op)
            CMP_CHAIN: begin
                subtr = opr;
                bin   = c_in;
                chain = 1'b1;
            end
            CMP_IMM: begin
                subtr = imm;
                bin   = 1'b0;
                chain = 1'b0;
            end
            default: begin
                subtr = opr;
                bin   = 1'b0;
                chain = 1'b0;
            end
        endcase
    end

    cmpflag_sub #(.W(W)) u_sub (
        .a     (opd),
        .b     (subtr),
        .bin   (bin),
        .diff  (diff),
        .bout  (bout),
        .hbout (hbout)
    );

    cmpflag_eval #(.W(W)) u_eval (
        .a      (opd),
        .b      (subtr),
        .diff   (diff),
        .bout   (bout),
        .hbout  (hbout),
        .chain  (chain),
        .z_prev (z_in),
        .flags  (flags_d)
    );

    // Flag register: CLEAR on reset, UPDATE on request, otherwise HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (cmp_go) begin
            flags_q <= flags_d;
        end
    end

    always_comb begin
        flag_z = flags_q.z;
        flag_c = flags_q.c;
        flag_n = flags_q.n;
        flag_v = flags_q.v;
        flag_s = flags_q.s;
        flag_h = flags_q.h;
    end
endmodule

// File: rtl/cmpflag_unit_chk.sv
module cmpflag_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmp_go,
    input logic [1:0]   cmp_op,
    input logic [W-1:0] opd,
    input logic [W-1:0] opr,
    input logic [W-1:0] imm,
    input logic         c_in,
    input logic         z_in,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_n,
    input logic         flag_v,
    input logic         flag_s,
    input logic         flag_h
);
    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go |=> $stable({flag_z, flag_c, flag_n, flag_v, flag_s, flag_h}));

    // R8
    chain_zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && cmp_op == 2'd1 && !z_in) |=> !flag_z);

    // R2
    equal_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && cmp_op == 2'd0 && opd == opr)
        |=> (flag_z && !flag_c && !flag_h && !flag_v && !flag_n));

    // R4
    equal_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && cmp_op == 2'd2 && opd == imm) |=> (flag_z && !flag_c));

    // R5
    unsigned_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && cmp_op == 2'd0 && opd < opr) |=> flag_c);

    // R6
    nibble_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && cmp_op == 2'd0 && opd[W/2-1:0] < opr[W/2-1:0]) |=> flag_h);
endmodule

bind cmpflag_unit cmpflag_unit_chk #(.W(W)) u_chk (.*);

// File: tb/cmpflag_unit_bench.sv
module cmpflag_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_go = 1'b0;
    logic [1:0] cmp_op = 2'd0;
    logic [7:0] opd = '0;
    logic [7:0] opr = '0;
    logic [7:0] imm = '0;
    logic       c_in = 1'b0;
    logic       z_in = 1'b0;
    logic       flag_z, flag_c, flag_n, flag_v, flag_s, flag_h;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;
    logic [5:0] last_exp = '0;

    always #4 clk = ~clk;

    cmpflag_unit u_cmpflag_unit (
        .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .cmp_op(cmp_op),
        .opd(opd), .opr(opr), .imm(imm), .c_in(c_in), .z_in(z_in),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
        .flag_v(flag_v), .flag_s(flag_s), .flag_h(flag_h)
    );

    // Reference model: flags packed as {z,c,n,v,s,h}, from integer arithmetic.
    function automatic logic [5:0] model(input logic [1:0] op, input logic [7:0] a,
                                         input logic [7:0] rr, input logic [7:0] k,
                                         input logic ci, input logic zi);
        int b, br, ud, ul, sd;
        logic [7:0] r;
        logic z, c, n, v, s, h;
        b   = (op == 2'd2) ? int'(k) : int'(rr);
        br  = (op == 2'd1) ? int'(ci) : 0;
        ud  = int'(a) - b - br;
        ul  = int'(a & 8'h0F) - (b & 15) - br;
        sd  = int'($signed(a)) - int'($signed(b[7:0])) - br;
        r   = ud[7:0];
        c   = (ud < 0);
        h   = (ul < 0);
        n   = r[7];
        v   = (sd < -128) || (sd > 127);
        s   = (sd < 0);
        z   = (op == 2'd1) ? ((r == 8'h00) && zi) : (r == 8'h00);
        return {z, c, n, v, s, h};
    endfunction

    task automatic drive(input logic [1:0] op, input logic [7:0] a, input logic [7:0] rr,
                         input logic [7:0] k, input logic ci, input logic zi, input string tag);
        item_t it;
        @(negedge clk);
        cmp_go = 1'b1; cmp_op = op; opd = a; opr = rr; imm = k; c_in = ci; z_in = zi;
        it.exp = model(op, a, rr, k, ci, zi);
        it.tag = tag;
        last_exp = it.exp;
        sb.push_back(it);
    endtask

    task automatic idle(input logic [7:0] a, input logic [7:0] rr, input string tag);
        item_t it;
        @(negedge clk);
        cmp_go = 1'b0; opd = a; opr = rr; imm = ~a; c_in = ~c_in; z_in = ~z_in;
        cmp_op = cmp_op + 2'd1;
        it.exp = last_exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: each stimulus cycle has one queue entry, checked after the edge.
    always @(posedge clk) begin
        if (rst_n && sb.size() > 0) begin
            item_t it;
            logic [5:0] got;
            it = sb.pop_front();
            #2;
            got = {flag_z, flag_c, flag_n, flag_v, flag_s, flag_h};
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s: flags zcnvsh actual=%b expected=%b", it.tag, got, it.exp);
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        opd = 8'h00; opr = 8'h01; cmp_go = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        total++;
        if ({flag_z, flag_c, flag_n, flag_v, flag_s, flag_h} !== 6'b0) begin
            bad++;
            $display("FAIL R1: actual=%b expected=000000",
                     {flag_z, flag_c, flag_n, flag_v, flag_s, flag_h});
        end
        @(negedge clk);
        cmp_go = 1'b0;
        rst_n = 1'b1;

        drive(2'd0, 8'h42, 8'h42, 8'h00, 1'b0, 1'b0, "R2 equal");
        drive(2'd0, 8'h50, 8'h20, 8'h00, 1'b0, 1'b0, "R2 greater");
        drive(2'd0, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, "R5 borrow out");
        drive(2'd0, 8'h10, 8'h01, 8'h00, 1'b0, 1'b0, "R6 nibble borrow");
        drive(2'd0, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0, "R7 overflow neg-pos");
        drive(2'd0, 8'h7F, 8'hFF, 8'h00, 1'b0, 1'b0, "R7 overflow pos-neg");
        drive(2'd1, 8'h12, 8'h12, 8'h00, 1'b0, 1'b1, "R8 chain zero keeps z high");
        drive(2'd1, 8'h12, 8'h12, 8'h00, 1'b0, 1'b0, "R8 chain zero keeps z low");
        drive(2'd1, 8'h12, 8'h12, 8'h00, 1'b1, 1'b1, "R3 chain borrow-in");
        drive(2'd1, 8'h34, 8'h20, 8'h00, 1'b1, 1'b1, "R3 chain nonzero clears z");
        drive(2'd2, 8'h33, 8'h99, 8'h33, 1'b0, 1'b0, "R4 imm equal, opr ignored");
        drive(2'd2, 8'h05, 8'h01, 8'h09, 1'b0, 1'b0, "R4 imm lower");
        drive(2'd0, 8'h42, 8'h42, 8'h00, 1'b1, 1'b0, "R10 c_in ignored reg");
        drive(2'd2, 8'h42, 8'h00, 8'h42, 1'b1, 1'b0, "R10 c_in ignored imm");
        drive(2'd3, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0, "R11 alt op as reg");
        drive(2'd3, 8'h77, 8'h77, 8'h00, 1'b1, 1'b0, "R11 alt op equal");
        drive(2'd0, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0, "R9 setup");
        idle(8'h00, 8'h00, "R9 hold 1");
        idle(8'hFF, 8'h01, "R9 hold 2");
        idle(8'h10, 8'h7F, "R9 hold 3");

        for (int i = 0; i < 300; i++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            drive(op, 8'($urandom), 8'($urandom), 8'($urandom),
                  1'($urandom), 1'($urandom), "R2 R3 R4 R7 R8 random");
        end

        @(negedge clk);
        cmp_go = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule